// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute step of a 32-bit integer pipeline. Each cycle it takes a decoded instruction: primary opcode, function field, constant shift amount, 16-bit immediate, the two source operand values and the destination register index. One rising clock edge later it presents the computed result, a write-enable for the register file, the destination index, and two flags. One flag marks an encoding the stage does not implement. The other marks signed overflow on the trapping add and subtract forms.

Decoding works in two levels. The primary opcode picks an immediate-form operation. Primary opcode 0 defers to the function field, which picks a register-form operation or a shift. The caller supplies the destination index that is already resolved for the instruction format. Writes aimed at index 0 are never enabled, so register 0 stays constant in the register file.

Top module: `exu_top`

## Requirements
- R1: While reset is low, and at the first sample after it, result_o, wr_en_o, dest_o, illegal_o and overflow_o are all zero.
- R2: Every output reflects the inputs captured at the previous rising clock edge. Back-to-back instructions each produce their own result one cycle later, and dest_o repeats dest_i.
- R3: Additions and subtractions wrap modulo 2^32. Register forms use opcode 0 with function 32 (ADD), 33 (ADDU), 34 (SUB) and 35 (SUBU). Immediate forms use opcode 8 (ADDI) and 9 (ADDIU), and they sign-extend the immediate.
- R4: ADD, ADDI and SUB set overflow_o on signed overflow and hold wr_en_o low, while result_o still carries the wrapped value. ADDU, ADDIU and SUBU never set overflow_o.
- R5: Function codes 36, 37, 38 and 39 give rs AND rt, OR, XOR and NOR. Opcodes 12, 13 and 14 give AND, OR and XOR with the immediate zero-extended.
- R6: Function 42 (signed) and 43 (unsigned) return 1 when rs < rt and 0 otherwise. Opcode 10 compares signed against the sign-extended immediate. Opcode 11 sign-extends the immediate and then compares unsigned.
- R7: Function codes 0, 2 and 3 shift rt by shamt_i: left logical, right logical (zero fill) and right arithmetic (sign fill).
- R8: Function codes 4, 6 and 7 shift rt in the same three ways by the amount in rs bits 4:0. The upper bits of rs are ignored.
- R9: Opcode 15 returns the immediate in bits 31:16 with bits 15:0 cleared.
- R10: When dest_i is 0, wr_en_o stays low for every operation. result_o still shows the computed value.
- R11: Any other primary opcode, or any other function code under opcode 0, sets illegal_o and gives wr_en_o=0, overflow_o=0 and result_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function field, used when opcode is 0 |
| shamt_i | input | 5 | Constant shift amount |
| imm_i | input | 16 | Immediate field |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| dest_i | input | 5 | Destination register index |
| result_o | output | 32 | Computed result |
| wr_en_o | output | 1 | Register-file write enable |
| dest_o | output | 5 | Registered destination index |
| illegal_o | output | 1 | Unsupported encoding |
| overflow_o | output | 1 | Signed overflow on ADD, ADDI or SUB |

## Verification
Operands are chosen at the sign boundaries (0x7fffffff, 0x80000000 and all ones), so that signed and unsigned compares give opposite answers. The same boundaries let trapping and wrapping arithmetic differ only in the flag. Immediates with bit 15 set separate zero extension from sign extension, and SLTIU shows that the sign-extended immediate is compared as unsigned. Shifts of a negative value separate zero fill from sign fill. A shift register value with upper bits set shows that only the low five bits count. Destination 0, unknown opcodes and unknown function codes check that the write is suppressed even when the result is otherwise valid.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN = 32;
    localparam int IMMW = 16;
    localparam int REGW = 5;
    localparam int SHW  = $clog2(XLEN);

    // primary opcodes
    localparam logic [5:0] OPC_REGFORM = 6'd0;
    localparam logic [5:0] OPC_ADDI    = 6'd8;
    localparam logic [5:0] OPC_ADDIU   = 6'd9;
    localparam logic [5:0] OPC_SLTI    = 6'd10;
    localparam logic [5:0] OPC_SLTIU   = 6'd11;
    localparam logic [5:0] OPC_ANDI    = 6'd12;
    localparam logic [5:0] OPC_ORI     = 6'd13;
    localparam logic [5:0] OPC_XORI    = 6'd14;
    localparam logic [5:0] OPC_LUI     = 6'd15;

    // function codes under OPC_REGFORM
    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SEXT, IMM_ZEXT, IMM_HIGH
    } imm_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic [REGW-1:0] dest;
        logic            illegal;
        logic            overflow;
    } exu_out_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output alu_op_e    op_o,
    output logic       use_imm_o,
    output imm_kind_e  imm_kind_o,
    output logic       ovf_chk_o,
    output logic       shift_var_o,
    output logic       illegal_o
);
    always_comb begin
        op_o        = OP_PASSB;
        use_imm_o   = 1'b0;
        imm_kind_o  = IMM_SEXT;
        ovf_chk_o   = 1'b0;
        shift_var_o = 1'b0;
        illegal_o   = 1'b0;
        if (opcode_i == OPC_REGFORM) begin
            unique case (funct_i)
                FN_SLL:  op_o = OP_SLL;
                FN_SRL:  op_o = OP_SRL;
                FN_SRA:  op_o = OP_SRA;
                FN_SLLV: begin op_o = OP_SLL; shift_var_o = 1'b1; end
                FN_SRLV: begin op_o = OP_SRL; shift_var_o = 1'b1; end
                FN_SRAV: begin op_o = OP_SRA; shift_var_o = 1'b1; end
                FN_ADD:  begin op_o = OP_ADD; ovf_chk_o = 1'b1; end
                FN_ADDU: op_o = OP_ADD;
                FN_SUB:  begin op_o = OP_SUB; ovf_chk_o = 1'b1; end
                FN_SUBU: op_o = OP_SUB;
                FN_AND:  op_o = OP_AND;
                FN_OR:   op_o = OP_OR;
                FN_XOR:  op_o = OP_XOR;
                FN_NOR:  op_o = OP_NOR;
                FN_SLT:  op_o = OP_SLT;
                FN_SLTU: op_o = OP_SLTU;
                default: illegal_o = 1'b1;
            endcase
        end else begin
            use_imm_o = 1'b1;
            unique case (opcode_i)
                OPC_ADDI:  begin op_o = OP_ADD; ovf_chk_o = 1'b1; end
                OPC_ADDIU: op_o = OP_ADD;
                OPC_SLTI:  op_o = OP_SLT;
                OPC_SLTIU: op_o = OP_SLTU;
                OPC_ANDI:  begin op_o = OP_AND; imm_kind_o = IMM_ZEXT; end
                OPC_ORI:   begin op_o = OP_OR;  imm_kind_o = IMM_ZEXT; end
                OPC_XORI:  begin op_o = OP_XOR; imm_kind_o = IMM_ZEXT; end
                OPC_LUI:   begin op_o = OP_PASSB; imm_kind_o = IMM_HIGH; end
                default:   illegal_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [AW+1];
    logic         fill;

    assign fill   = arith_i & ~left_i & data_i[W-1];
    assign stg[0] = left_i ? rev_in : data_i;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data_i[W-1-i];
        assign rev_out[i] = stg[AW][W-1-i];
    end

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
    end

    assign data_o = left_i ? rev_out : stg[AW];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         ovf_o
);
    logic         sub;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;

    assign sub   = (op_i == OP_SUB);
    assign b_eff = sub ? ~b_i : b_i;
    assign sum   = a_i + b_eff + {{(W-1){1'b0}}, sub};
    assign ovf_o = (op_i == OP_ADD || op_i == OP_SUB)
                 && (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB: result_o = sum;
            OP_AND:  result_o = a_i & b_i;
            OP_OR:   result_o = a_i | b_i;
            OP_XOR:  result_o = a_i ^ b_i;
            OP_NOR:  result_o = ~(a_i | b_i);
            OP_SLT:  result_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            OP_SLTU: result_o = {{(W-1){1'b0}}, (a_i < b_i)};
            default: result_o = b_i;
        endcase
    end
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       opcode_i,
    input  logic [5:0]       funct_i,
    input  logic [SHW-1:0]   shamt_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    input  logic [REGW-1:0]  dest_i,
    output logic [XLEN-1:0]  result_o,
    output logic             wr_en_o,
    output logic [REGW-1:0]  dest_o,
    output logic             illegal_o,
    output logic             overflow_o
);
    localparam int EXTW = XLEN - IMMW;

    alu_op_e   dec_op;
    imm_kind_e dec_imm;
    logic      dec_use_imm, dec_ovf_chk, dec_shvar, dec_illegal;

    logic [XLEN-1:0] imm_ext, opnd_b, alu_res, sh_res;
    logic [SHW-1:0]  sh_amt;
    logic            alu_ovf, is_shift;

    exu_out_t nxt_d, out_q;

    exu_decode u_decode (
        .opcode_i    (opcode_i),
        .funct_i     (funct_i),
        .op_o        (dec_op),
        .use_imm_o   (dec_use_imm),
        .imm_kind_o  (dec_imm),
        .ovf_chk_o   (dec_ovf_chk),
        .shift_var_o (dec_shvar),
        .illegal_o   (dec_illegal)
    );

    always_comb begin
        unique case (dec_imm)
            IMM_ZEXT: imm_ext = {{EXTW{1'b0}}, imm_i};
            IMM_HIGH: imm_ext = {imm_i, {EXTW{1'b0}}};
            default:  imm_ext = {{EXTW{imm_i[IMMW-1]}}, imm_i};
        endcase
    end

    assign opnd_b   = dec_use_imm ? imm_ext : rt_val_i;
    assign sh_amt   = dec_shvar ? rs_val_i[SHW-1:0] : shamt_i;
    assign is_shift = (dec_op == OP_SLL) || (dec_op == OP_SRL) || (dec_op == OP_SRA);

    exu_alu u_alu (
        .op_i     (dec_op),
        .a_i      (rs_val_i),
        .b_i      (opnd_b),
        .result_o (alu_res),
        .ovf_o    (alu_ovf)
    );

    exu_shift u_shift (
        .data_i  (rt_val_i),
        .amt_i   (sh_amt),
        .left_i  (dec_op == OP_SLL),
        .arith_i (dec_op == OP_SRA),
        .data_o  (sh_res)
    );

    always_comb begin
        nxt_d          = '0;
        nxt_d.dest     = dest_i;
        nxt_d.illegal  = dec_illegal;
        if (!dec_illegal) begin
            nxt_d.result   = is_shift ? sh_res : alu_res;
            nxt_d.overflow = dec_ovf_chk & alu_ovf;
            nxt_d.wr_en    = !(dec_ovf_chk & alu_ovf) && (dest_i != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt_d;
    end

    assign result_o   = out_q.result;
    assign wr_en_o    = out_q.wr_en;
    assign dest_o     = out_q.dest;
    assign illegal_o  = out_q.illegal;
    assign overflow_o = out_q.overflow;

    logic cmp_in;
    assign cmp_in = (opcode_i == OPC_SLTI) || (opcode_i == OPC_SLTIU) ||
                    ((opcode_i == OPC_REGFORM) && (funct_i == FN_SLT || funct_i == FN_SLTU));

    AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_o == '0) |-> !wr_en_o); // R10
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !overflow_o && result_o == '0)); // R11
    AST_OVERFLOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> !wr_en_o); // R4
    AST_COMPARE_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_in |=> (result_o[XLEN-1:1] == '0)); // R6
    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == OPC_LUI) |=> (result_o[EXTW-1:0] == '0 && result_o[XLEN-1:EXTW] == $past(imm_i))); // R9
    AST_DEST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dest_o == $past(dest_i))); // R2
endmodule

// File: tb/exu_top_bench.sv
module exu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode_i = '0, funct_i = '0;
    logic [4:0]  shamt_i = '0, dest_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] rs_val_i = '0, rt_val_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o, illegal_o, overflow_o;
    logic [4:0]  dest_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        we;
        logic [4:0]  dst;
        logic        ill;
        logic        ovf;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    exu_top u_exu_top (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .funct_i(funct_i),
        .shamt_i(shamt_i), .imm_i(imm_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .dest_i(dest_i), .result_o(result_o), .wr_en_o(wr_en_o), .dest_o(dest_o),
        .illegal_o(illegal_o), .overflow_o(overflow_o)
    );

    function automatic exp_t model(string tag, logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                                   logic [15:0] im, logic [31:0] a, logic [31:0] b, logic [4:0] d);
        exp_t e;
        logic [31:0] sx, zx;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        e.tag = tag; e.res = '0; e.ill = 1'b0; e.ovf = 1'b0; e.dst = d;
        if (op == 6'd0) begin
            case (fn)
                6'd0:  e.res = b << sh;
                6'd2:  e.res = b >> sh;
                6'd3:  e.res = $signed(b) >>> sh;
                6'd4:  e.res = b << a[4:0];
                6'd6:  e.res = b >> a[4:0];
                6'd7:  e.res = $signed(b) >>> a[4:0];
                6'd32: begin e.res = a + b; e.ovf = (a[31] == b[31]) && (e.res[31] != a[31]); end
                6'd33: e.res = a + b;
                6'd34: begin e.res = a - b; e.ovf = (a[31] != b[31]) && (e.res[31] != a[31]); end
                6'd35: e.res = a - b;
                6'd36: e.res = a & b;
                6'd37: e.res = a | b;
                6'd38: e.res = a ^ b;
                6'd39: e.res = ~(a | b);
                6'd42: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'd43: e.res = (a < b) ? 32'd1 : 32'd0;
                default: e.ill = 1'b1;
            endcase
        end else begin
            case (op)
                6'd8:  begin e.res = a + sx; e.ovf = (a[31] == sx[31]) && (e.res[31] != a[31]); end
                6'd9:  e.res = a + sx;
                6'd10: e.res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
                6'd11: e.res = (a < sx) ? 32'd1 : 32'd0;
                6'd12: e.res = a & zx;
                6'd13: e.res = a | zx;
                6'd14: e.res = a ^ zx;
                6'd15: e.res = {im, 16'h0};
                default: e.ill = 1'b1;
            endcase
        end
        if (e.ill) e.res = '0;
        e.we = !e.ill && !e.ovf && (d != 5'd0);
        return e;
    endfunction

    // driver: one instruction per cycle, expected item queued after the capturing edge
    task automatic apply(string tag, logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                         logic [15:0] im, logic [31:0] a, logic [31:0] b, logic [4:0] d);
        @(negedge clk);
        opcode_i = op; funct_i = fn; shamt_i = sh; imm_i = im;
        rs_val_i = a; rt_val_i = b; dest_i = d;
        @(posedge clk);
        #1;
        sb.push_back(model(tag, op, fn, sh, im, a, b, d));
    endtask

    // monitor
    always begin
        @(negedge clk);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (result_o !== e.res || wr_en_o !== e.we || dest_o !== e.dst ||
                illegal_o !== e.ill || overflow_o !== e.ovf) begin
                n_fails++;
                $display("FAIL %s: got res=%h we=%b dst=%0d ill=%b ovf=%b, exp res=%h we=%b dst=%0d ill=%b ovf=%b",
                         e.tag, result_o, wr_en_o, dest_o, illegal_o, overflow_o,
                         e.res, e.we, e.dst, e.ill, e.ovf);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, inputs held non-zero
        opcode_i = 6'd9; imm_i = 16'h1234; rs_val_i = 32'h55; dest_i = 5'd7;
        repeat (3) @(negedge clk);
        n_checks++;
        if (result_o !== 0 || wr_en_o !== 0 || dest_o !== 0 || illegal_o !== 0 || overflow_o !== 0) begin
            n_fails++;
            $display("FAIL R1: got res=%h we=%b dst=%0d ill=%b ovf=%b, exp all zero",
                     result_o, wr_en_o, dest_o, illegal_o, overflow_o);
        end
        rst_n = 1'b1;

        // R3 arithmetic, wrapping and sign-extended immediates (back to back: R2)
        apply("R3 addu",  0, 33, 0, 0,       32'd5,        32'd7,        5'd3);
        apply("R2 back-to-back add", 0, 32, 0, 0, 32'h7fff0000, 32'h10, 5'd4);
        apply("R3 subu wrap", 0, 35, 0, 0,  32'd3,        32'd5,        5'd5);
        apply("R3 addi sext", 8, 0, 0, 16'hffff, 32'd100, 32'hdead, 5'd6);
        apply("R3 sub",   0, 34, 0, 0,       32'd50,       32'd8,        5'd7);
        // R4 overflow
        apply("R4 add ovf",   0, 32, 0, 0,   32'h7fffffff, 32'd1,        5'd8);
        apply("R4 sub ovf",   0, 34, 0, 0,   32'h80000000, 32'd1,        5'd9);
        apply("R4 addi ovf",  8, 0, 0, 16'd1, 32'h7fffffff, 32'd0,       5'd10);
        apply("R4 addu no flag", 0, 33, 0, 0, 32'h7fffffff, 32'd1,       5'd11);
        apply("R4 subu no flag", 0, 35, 0, 0, 32'h80000000, 32'd1,       5'd12);
        apply("R4 addiu no flag", 9, 0, 0, 16'd1, 32'h7fffffff, 32'd0,   5'd13);
        apply("R4 ovf with dest0", 0, 32, 0, 0, 32'h80000000, 32'h80000000, 5'd0);
        // R5 logic
        apply("R5 and",  0, 36, 0, 0, 32'hf0f0_1234, 32'h0ff0_ff00, 5'd1);
        apply("R5 or",   0, 37, 0, 0, 32'hf0f0_1234, 32'h0ff0_ff00, 5'd1);
        apply("R5 xor",  0, 38, 0, 0, 32'hf0f0_1234, 32'h0ff0_ff00, 5'd1);
        apply("R5 nor",  0, 39, 0, 0, 32'hf0f0_1234, 32'h0ff0_ff00, 5'd1);
        apply("R5 andi zext", 12, 0, 0, 16'h8001, 32'hffffffff, 32'h0, 5'd2);
        apply("R5 ori zext",  13, 0, 0, 16'h8000, 32'h00000001, 32'h0, 5'd2);
        apply("R5 xori zext", 14, 0, 0, 16'hffff, 32'hffff0000, 32'h0, 5'd2);
        // R6 compares
        apply("R6 slt",   0, 42, 0, 0, 32'hffffffff, 32'd1, 5'd3);
        apply("R6 sltu",  0, 43, 0, 0, 32'hffffffff, 32'd1, 5'd3);
        apply("R6 slti",  10, 0, 0, 16'hfffd, 32'hfffffffb, 32'd0, 5'd3);
        apply("R6 slti false", 10, 0, 0, 16'h0001, 32'h7fffffff, 32'd0, 5'd3);
        apply("R6 sltiu big imm", 11, 0, 0, 16'hffff, 32'd5, 32'd0, 5'd3);
        apply("R6 sltiu equal", 11, 0, 0, 16'hffff, 32'hffffffff, 32'd0, 5'd3);
        // R7 constant shifts
        apply("R7 sll",  0, 0, 5'd31, 0, 32'h0, 32'd1, 5'd4);
        apply("R7 srl",  0, 2, 5'd4,  0, 32'h0, 32'h80000000, 5'd4);
        apply("R7 sra",  0, 3, 5'd4,  0, 32'h0, 32'h80000000, 5'd4);
        apply("R7 sra zero", 0, 3, 5'd0, 0, 32'h0, 32'h80000001, 5'd4);
        // R8 variable shifts, upper rs bits ignored
        apply("R8 sllv", 0, 4, 5'd9, 0, 32'h00000021, 32'd3, 5'd5);
        apply("R8 srlv", 0, 6, 5'd0, 0, 32'hffffffff, 32'hf0000000, 5'd5);
        apply("R8 srav", 0, 7, 5'd0, 0, 32'hffffff08, 32'h80001234, 5'd5);
        // R9 lui
        apply("R9 lui",  15, 0, 0, 16'hbeef, 32'h12345678, 32'h0, 5'd6);
        // R10 dest 0
        apply("R10 addu dest0", 0, 33, 0, 0, 32'd1, 32'd2, 5'd0);
        apply("R10 ori dest0",  13, 0, 0, 16'h00ff, 32'd0, 32'd0, 5'd0);
        apply("R10 lui dest0",  15, 0, 0, 16'h1234, 32'd0, 32'd0, 5'd0);
        // R11 illegal encodings
        apply("R11 opcode 2",  2, 0, 0, 16'h1, 32'd1, 32'd1, 5'd7);
        apply("R11 opcode 35", 35, 0, 0, 16'h4, 32'd8, 32'd1, 5'd7);
        apply("R11 opcode 63", 63, 0, 0, 16'h4, 32'd8, 32'd1, 5'd7);
        apply("R11 funct 1",  0, 1, 0, 0, 32'd1, 32'd1, 5'd7);
        apply("R11 funct 24", 0, 24, 0, 0, 32'h7fffffff, 32'h7fffffff, 5'd7);
        apply("R11 funct 63", 0, 63, 0, 0, 32'd1, 32'd1, 5'd7);
        apply("R2 after illegal", 0, 33, 0, 0, 32'd10, 32'd20, 5'd8);

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule